// File: doc/BRIEF.md
# Fixed-Priority Interrupt Token Chain

This block picks one interrupt to serve from a set of request lines that have already been masked. When the core raises its ready input, a grant token enters the chain at request line 0. It moves to the next line only while the current line is idle. The first requesting line keeps the token and becomes the single grant. In the same cycle the block raises its interrupt output and builds a trap cause word. That word carries the grant as a one-hot field under a header that flags an interrupt.

The arbitration and the cause word are combinational. The only state is a register that captures the one-hot grant on every clock edge where the interrupt output is high. When the core later signals return from the handler, this stored grant goes back as a one-hot acknowledge to the source that was served. With the return input low, the acknowledge stays all zeros.

Top module: `irq_prio_chain`

## Requirements
- R1: In any cycle where `core_ready` is 1 and at least one bit of `req_masked` is 1, `irq_out` is 1 in that same cycle. With no request pending, `irq_out` is 0.
- R2: In any cycle where `core_ready` is 0, `irq_out` is 0 and no grant is formed, whatever `req_masked` holds.
- R3: While `irq_out` is 1, `cause_out[19:4]` holds exactly one set bit, at position 4+i, where i is the lowest-numbered request line that is set. Line 0 has the highest priority and maps to bit 4.
- R4: While `irq_out` is 1, `cause_out[31]` is 1, `cause_out[30:20]` are 0 and `cause_out[3:0]` are 0, so `cause_out[31:20]` reads 0x800.
- R5: While `irq_out` is 0, `cause_out` is all zeros.
- R6: On each rising clock edge where `irq_out` is 1, the one-hot grant is stored. On edges where `irq_out` is 0, the stored grant keeps its value.
- R7: While `handler_ret` is 1, `ack_out` equals the stored one-hot grant, with bit i standing for request line i. While `handler_ret` is 0, `ack_out` is all zeros.
- R8: While `rst` is 1 (synchronous, active high) on a clock edge, the stored grant is cleared. After reset and before any interrupt, `ack_out` is therefore zero even with `handler_ret` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| core_ready | input | 1 | Core can accept an interrupt; injects the grant token |
| handler_ret | input | 1 | Core is returning from the interrupt handler |
| req_masked | input | 16 | Masked interrupt requests, bit 0 highest priority |
| irq_out | output | 1 | Interrupt to the core |
| ack_out | output | 16 | One-hot acknowledge to the served source |
| cause_out | output | 32 | Trap cause word with the one-hot grant field |

## Verification
`irq_out` and `cause_out` are due in the same cycle the inputs change. The bench drives inputs on the falling edge and compares these outputs a few nanoseconds later, well before the next rising edge. The stored grant changes only at the rising edge after a cycle with `irq_out` high. The reference model updates its own copy at that same edge, so each `ack_out` comparison in the following half-cycle uses the grant from the previous edge. Reset checks sample after the edge that applied reset.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

   // Structure used to form the grant
   typedef enum logic {
      CHAIN_RIPPLE  = 1'b0,   // explicit token passed line by line
      CHAIN_ISOLATE = 1'b1    // lowest-set-bit isolation by two's complement
   } chain_style_e;

   // Header field width above the one-hot field
   function automatic int hdr_width(input int cause_w, input int field_lsb, input int nsrc);
      return cause_w - field_lsb - nsrc;
   endfunction

endpackage

// File: rtl/prio_token_chain.sv
module prio_token_chain
   import irq_chain_pkg::*;
#(
   parameter int           NUM_SRC = 16,
   parameter chain_style_e STYLE   = CHAIN_RIPPLE
) (
   input  logic               token_in,
   input  logic [NUM_SRC-1:0] req,
   output logic [NUM_SRC-1:0] grant,
   output logic               any_grant
);

   generate
      if (STYLE == CHAIN_RIPPLE) begin : g_ripple
         logic [NUM_SRC:0] token;
         assign token[0] = token_in;
         for (genvar i = 0; i < NUM_SRC; i++) begin : g_link
            assign grant[i]   = req[i] & token[i];
            assign token[i+1] = token[i] & ~req[i];
         end
      end else begin : g_isolate
         logic [NUM_SRC-1:0] low_bit;
         assign low_bit = req & (~req + NUM_SRC'(1));
         assign grant   = token_in ? low_bit : '0;
      end
   endgenerate

   assign any_grant = |grant;

endmodule

// File: rtl/cause_word_build.sv
module cause_word_build #(
   parameter int NUM_SRC   = 16,
   parameter int CAUSE_W   = 32,
   parameter int FIELD_LSB = 4
) (
   input  logic               valid,
   input  logic [NUM_SRC-1:0] onehot,
   output logic [CAUSE_W-1:0] cause
);

   always_comb begin
      cause = '0;
      if (valid) begin
         cause[CAUSE_W-1]             = 1'b1;
         cause[FIELD_LSB +: NUM_SRC]  = onehot;
      end
   end

endmodule

// File: rtl/grant_capture.sv
module grant_capture #(
   parameter int NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [NUM_SRC-1:0] grant_d,
   input  logic               ret,
   output logic [NUM_SRC-1:0] ack
);

   logic [NUM_SRC-1:0] grant_q;

   always_ff @(posedge clk) begin
      if (rst)       grant_q <= '0;
      else if (load) grant_q <= grant_d;
   end

   assign ack = ret ? grant_q : '0;

endmodule

// File: rtl/irq_prio_chain.sv
module irq_prio_chain
   import irq_chain_pkg::*;
#(
   parameter int           NUM_SRC   = 16,
   parameter int           CAUSE_W   = 32,
   parameter int           FIELD_LSB = 4,
   parameter chain_style_e STYLE     = CHAIN_RIPPLE
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               core_ready,
   input  logic               handler_ret,
   input  logic [NUM_SRC-1:0] req_masked,
   output logic               irq_out,
   output logic [NUM_SRC-1:0] ack_out,
   output logic [CAUSE_W-1:0] cause_out
);

   localparam int HDR_W = hdr_width(CAUSE_W, FIELD_LSB, NUM_SRC);

   generate
      if (NUM_SRC < 1) begin : g_bad_nsrc
         $error("NUM_SRC must be at least 1");
      end
      if (HDR_W < 1) begin : g_bad_hdr
         $error("cause word too narrow for header and one-hot field");
      end
      if (FIELD_LSB < 0) begin : g_bad_lsb
         $error("FIELD_LSB must not be negative");
      end
   endgenerate

   logic [NUM_SRC-1:0] grant;
   logic               any_grant;

   prio_token_chain #(
      .NUM_SRC (NUM_SRC),
      .STYLE   (STYLE)
   ) chain_i (
      .token_in  (core_ready),
      .req       (req_masked),
      .grant     (grant),
      .any_grant (any_grant)
   );

   cause_word_build #(
      .NUM_SRC   (NUM_SRC),
      .CAUSE_W   (CAUSE_W),
      .FIELD_LSB (FIELD_LSB)
   ) cause_i (
      .valid  (any_grant),
      .onehot (grant),
      .cause  (cause_out)
   );

   grant_capture #(
      .NUM_SRC (NUM_SRC)
   ) capture_i (
      .clk     (clk),
      .rst     (rst),
      .load    (any_grant),
      .grant_d (grant),
      .ret     (handler_ret),
      .ack     (ack_out)
   );

   assign irq_out = any_grant;

endmodule

// File: rtl/irq_prio_chain_chk.sv
module irq_prio_chain_chk #(
   parameter int NUM_SRC   = 16,
   parameter int CAUSE_W   = 32,
   parameter int FIELD_LSB = 4
) (
   input logic               clk,
   input logic               rst,
   input logic               core_ready,
   input logic               handler_ret,
   input logic [NUM_SRC-1:0] req_masked,
   input logic               irq_out,
   input logic [NUM_SRC-1:0] ack_out,
   input logic [CAUSE_W-1:0] cause_out
);

   localparam int HDR_W = CAUSE_W - FIELD_LSB - NUM_SRC;
   localparam logic [HDR_W-1:0] HDR_EXP = HDR_W'(1) << (HDR_W - 1);

   logic past_ok;
   always_ff @(posedge clk) begin
      if (rst) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
   end

   // R1
   ready_req_irq_chk: assert property (@(posedge clk) disable iff (rst)
      (core_ready && (|req_masked)) |-> irq_out);

   // R2
   not_ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !core_ready |-> !irq_out);

   // R3
   cause_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      irq_out |-> $onehot(cause_out[FIELD_LSB +: NUM_SRC]));

   // R3
   grant_is_pending_chk: assert property (@(posedge clk) disable iff (rst)
      irq_out |-> ((cause_out[FIELD_LSB +: NUM_SRC] & ~req_masked) == '0));

   // R4
   cause_frame_chk: assert property (@(posedge clk) disable iff (rst)
      irq_out |-> (cause_out[CAUSE_W-1 -: HDR_W] == HDR_EXP)
               && (cause_out[FIELD_LSB-1:0] == '0));

   // R5
   idle_cause_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !irq_out |-> (cause_out == '0));

   // R6
   ack_follows_grant_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && handler_ret && $past(irq_out))
         |-> (ack_out == $past(cause_out[FIELD_LSB +: NUM_SRC])));

   // R6
   ack_held_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && handler_ret && $past(handler_ret) && !$past(irq_out))
         |-> $stable(ack_out));

   // R7
   ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !handler_ret |-> (ack_out == '0));

   // R7
   ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ack_out));

endmodule

bind irq_prio_chain irq_prio_chain_chk #(
   .NUM_SRC   (NUM_SRC),
   .CAUSE_W   (CAUSE_W),
   .FIELD_LSB (FIELD_LSB)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .core_ready  (core_ready),
   .handler_ret (handler_ret),
   .req_masked  (req_masked),
   .irq_out     (irq_out),
   .ack_out     (ack_out),
   .cause_out   (cause_out)
);

// File: tb/irq_prio_chain_tb_top.sv
`timescale 1ns/1ps
module irq_prio_chain_tb_top;

   localparam int N  = 16;
   localparam int CW = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          core_ready = 1'b0;
   logic          handler_ret = 1'b0;
   logic [N-1:0]  req_masked = '0;
   logic          irq_out;
   logic [N-1:0]  ack_out;
   logic [CW-1:0] cause_out;

   int checks = 0;
   int errors = 0;

   // reference state: grant stored at the last edge with a grant
   logic [N-1:0] mdl_stored = '0;

   always #10 clk = ~clk;   // 50 MHz

   irq_prio_chain dut_i (
      .clk         (clk),
      .rst         (rst),
      .core_ready  (core_ready),
      .handler_ret (handler_ret),
      .req_masked  (req_masked),
      .irq_out     (irq_out),
      .ack_out     (ack_out),
      .cause_out   (cause_out)
   );

   task automatic check(input string tag, input string what,
                        input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // expected grant from the requirements: lowest set line wins when ready
   function automatic logic [N-1:0] ref_grant(input logic rdy, input logic [N-1:0] r);
      logic [N-1:0] g = '0;
      if (rdy) begin
         for (int i = 0; i < N; i++) begin
            if (r[i]) begin
               g[i] = 1'b1;
               break;
            end
         end
      end
      return g;
   endfunction

   // drive on falling edge, compare mid-cycle, update model at rising edge
   task automatic step(input logic rdy, input logic ret, input logic [N-1:0] r);
      logic [N-1:0]  g;
      logic          e_irq;
      logic [CW-1:0] e_cause;
      @(negedge clk);
      core_ready  = rdy;
      handler_ret = ret;
      req_masked  = r;
      #3;
      g       = ref_grant(rdy, r);
      e_irq   = (g != '0);
      e_cause = '0;
      if (e_irq) begin
         e_cause[31]   = 1'b1;
         e_cause[19:4] = g;
      end
      check(rdy ? "R1" : "R2", "irq_out", CW'(irq_out), CW'(e_irq));
      if (e_irq) begin
         check("R3", "cause field", CW'(cause_out[19:4]), CW'(g));
         check("R4", "cause frame", {cause_out[31:20], 16'h0, cause_out[3:0]},
               {12'h800, 16'h0, 4'h0});
      end else begin
         check("R5", "cause idle", cause_out, '0);
      end
      if (ret) check("R6", "ack stored grant", CW'(ack_out), CW'(mdl_stored));
      else     check("R7", "ack idle", CW'(ack_out), '0);
      @(posedge clk);
      if (e_irq) mdl_stored = g;
   endtask

   initial begin : watchdog
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      // reset phase: R8
      rst = 1'b1;
      handler_ret = 1'b1;
      repeat (2) @(posedge clk);
      #3;
      check("R8", "ack in reset", CW'(ack_out), '0);
      @(negedge clk);
      rst = 1'b0;
      #3;
      check("R8", "ack after reset", CW'(ack_out), '0);
      check("R8", "irq after reset", CW'(irq_out), '0);
      mdl_stored = '0;

      // R1: ready with nothing pending, then each line alone
      step(1'b1, 1'b0, '0);
      for (int i = 0; i < N; i++) step(1'b1, 1'b1, N'(1) << i);

      // R3: priority among several pending lines
      step(1'b1, 1'b1, 16'hFFFF);
      step(1'b1, 1'b1, 16'hA0A0);
      step(1'b1, 1'b1, 16'h8000);
      step(1'b1, 1'b1, 16'h0300);

      // R2: not ready blocks all requests; R6 stored grant is held
      step(1'b0, 1'b1, 16'hFFFF);
      step(1'b0, 1'b1, 16'h0001);
      step(1'b1, 1'b0, 16'h0200);
      step(1'b0, 1'b1, 16'h0001);
      step(1'b0, 1'b1, 16'h0000);
      step(1'b1, 1'b1, 16'h0000);

      // R8: reset clears a stored grant
      step(1'b1, 1'b1, 16'h0040);
      @(negedge clk);
      rst = 1'b1;
      core_ready = 1'b0;
      handler_ret = 1'b1;
      @(posedge clk);
      #3;
      check("R8", "ack cleared by reset", CW'(ack_out), '0);
      @(negedge clk);
      rst = 1'b0;
      mdl_stored = '0;

      // random traffic
      for (int k = 0; k < 4000; k++) begin
         logic [N-1:0] r;
         r = N'($urandom);
         if ((k % 4) == 0) r = r & N'($urandom);
         if ((k % 7) == 0) r = '0;
         step(1'($urandom), 1'($urandom), r);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule